// File: doc/BRIEF.md
# Split 64-bit Time Base with Coherent Snapshot Reader

This block keeps a free-running 64-bit time count stored as two independent halves, a low word and a high word, each `HALF_W` bits wide. The count advances by one either once per `DIV` bus clocks (divided mode) or once per rising edge of an asynchronous external tick (external mode). A select input chooses the mode. Each half has its own write port and its own read port. No port ever exposes the full 64 bits in a single access, and nothing freezes or latches the count.

A hardware snapshot engine sits beside the counter and returns a tear-free 64-bit value. It uses only half-width reads. On a request it reads the high word, then the low word, then the high word again. If the two high values differ, a carry crossed the boundary during the sequence, so the engine discards the pair and repeats the three reads. When the two high values match, it returns the high value joined with the low value read between them, and it raises a one-cycle done pulse.

Top module: `hwtime_core`

## Requirements
- R1: While reset is asserted and directly after it, the count is zero, both read-data outputs are zero, `snap_done` is 0 and `snap_value` is zero.
- R2: With `clk_sel`=0, the count increases by exactly one on every DIV-th (8th) clock edge. The first increment lands on the 8th edge after reset or after the last write.
- R3: With `clk_sel`=1, each rising edge of `ext_tick` increases the count by exactly one, two clocks after the first edge that samples it high. The divider has no effect in this mode.
- R4: A write loads only the addressed half, suppresses counting on that edge and restarts the divider. A low-word write leaves the high word unchanged.
- R5: A read enable on either half returns that half, as it stood before the edge, on the read-data output one clock later. The output holds until the next enabled read.
- R6: An increment while the low word is all ones clears the low word and adds one to the high word.
- R7: After a request is sampled, the engine reads high, low and high on the next three edges and compares on the fourth. When the two high values match, `snap_done` rises 4 clocks after the request edge.
- R8: When the two high values differ, the engine restarts the three-read sequence. Each retry adds 4 clocks. The result is always the matching high value joined with the low value read between the two high reads.
- R9: `snap_done` is high for exactly one clock. `snap_value` holds its value until the next completion.
- R10: A request that arrives while a snapshot is in progress is ignored. It neither restarts the sequence nor produces an extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 0: divided bus clock, 1: external tick |
| ext_tick | input | 1 | Asynchronous external tick |
| wr_lo_en | input | 1 | Write strobe for the low word |
| wr_lo_data | input | HALF_W | Data for the low word |
| wr_hi_en | input | 1 | Write strobe for the high word |
| wr_hi_data | input | HALF_W | Data for the high word |
| rd_lo_en | input | 1 | Read strobe for the low word |
| rd_lo_data | output | HALF_W | Registered low-word read data |
| rd_hi_en | input | 1 | Read strobe for the high word |
| rd_hi_data | output | HALF_W | Registered high-word read data |
| snap_req | input | 1 | Start a coherent 64-bit snapshot |
| snap_done | output | 1 | One-cycle completion pulse |
| snap_value | output | 2*HALF_W | Coherent snapshot result |

## Verification
The bench builds the block with its defaults: HALF_W=32, DIV=8 and a two-stage synchronizer. With full 32-bit halves, a low word preset to all ones can only carry into the high word through the real increment path. Because DIV is 8 and every write restarts the divider, the bench knows the edge of each increment exactly. It can therefore place a request so that the carry lands between the first and second high reads, before the first read, or just after the sequence, and confirm for each case both the retry latency and the untorn result.

// File: rtl/hwtime_pkg.sv
package hwtime_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_HI_FIRST,
    RS_LO_MID,
    RS_HI_SECOND,
    RS_CMP
  } rd_state_e;
endpackage

// File: rtl/hwtime_tick.sv
module hwtime_tick #(
  parameter int DIV  = 8,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_sel,
  input  logic ext_tick,
  input  logic restart,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [PW-1:0]   pre_q;
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            div_tick;
  logic            ext_rise;

  assign div_tick = (pre_q == PRE_LAST) && !restart;
  assign ext_rise = sync_q[SYNC-1] && !prev_q;
  assign tick_o   = clk_sel ? ext_rise : div_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart || pre_q == PRE_LAST) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  generate
    if (SYNC == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_tick;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC-2:0], ext_tick};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC-1];
  end

  // Independent gap counter: cycles since the last divided tick or restart.
  logic [PW:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap_q <= '0;
    else if (div_tick || restart)  gap_q <= '0;
    else if (gap_q != '1)          gap_q <= gap_q + 1'b1;
  end

  assert_div_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> (gap_q == (PW+1)'(DIV - 1)));

  assert_ext_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/hwtime_count.sv
module hwtime_count #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              wr_lo_en,
  input  logic [HALF_W-1:0] wr_lo_data,
  input  logic              wr_hi_en,
  input  logic [HALF_W-1:0] wr_hi_data,
  input  logic              rd_lo_en,
  input  logic              rd_hi_en,
  output logic [HALF_W-1:0] rd_lo_data,
  output logic [HALF_W-1:0] rd_hi_data,
  output logic [HALF_W-1:0] lo_q,
  output logic [HALF_W-1:0] hi_q
);
  localparam int FULL_W = 2 * HALF_W;

  function automatic logic [FULL_W-1:0] bump(input logic [HALF_W-1:0] hi,
                                             input logic [HALF_W-1:0] lo);
    return {hi, lo} + FULL_W'(1);
  endfunction

  logic              any_wr;
  logic              count_en;
  logic              lo_wrap;
  logic [FULL_W-1:0] next_full;

  assign any_wr    = wr_lo_en || wr_hi_en;
  assign count_en  = step && !any_wr;
  assign lo_wrap   = count_en && (lo_q == '1);
  assign next_full = bump(hi_q, lo_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (any_wr) begin
      if (wr_lo_en) lo_q <= wr_lo_data;
      if (wr_hi_en) hi_q <= wr_hi_data;
    end else if (count_en) begin
      {hi_q, lo_q} <= next_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_lo_data <= '0;
      rd_hi_data <= '0;
    end else begin
      if (rd_lo_en) rd_lo_data <= lo_q;
      if (rd_hi_en) rd_hi_data <= hi_q;
    end
  end

  assert_lo_write_keeps_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_en && !wr_hi_en) |=> (hi_q == $past(hi_q)));

  assert_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> (lo_q == '0) && (hi_q == $past(hi_q) + 1'b1));

  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_en |=> (rd_lo_data == $past(lo_q)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !any_wr) |=> (lo_q == $past(lo_q)) && (hi_q == $past(hi_q)));
endmodule

// File: rtl/hwtime_snap.sv
module hwtime_snap
  import hwtime_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [HALF_W-1:0]     lo_in,
  input  logic [HALF_W-1:0]     hi_in,
  output logic                  done,
  output logic [2*HALF_W-1:0]   value
);
  function automatic logic halves_agree(input logic [HALF_W-1:0] a,
                                        input logic [HALF_W-1:0] b);
    return a == b;
  endfunction

  function automatic logic [2*HALF_W-1:0] join_words(input logic [HALF_W-1:0] hi,
                                                     input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  rd_state_e         state_q;
  logic [HALF_W-1:0] hi_a_q, lo_m_q, hi_b_q;
  logic              pair_ok;

  assign pair_ok = halves_agree(hi_a_q, hi_b_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      hi_a_q  <= '0;
      lo_m_q  <= '0;
      hi_b_q  <= '0;
      done    <= 1'b0;
      value   <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        RS_IDLE: if (req) state_q <= RS_HI_FIRST;
        RS_HI_FIRST: begin
          hi_a_q  <= hi_in;
          state_q <= RS_LO_MID;
        end
        RS_LO_MID: begin
          lo_m_q  <= lo_in;
          state_q <= RS_HI_SECOND;
        end
        RS_HI_SECOND: begin
          hi_b_q  <= hi_in;
          state_q <= RS_CMP;
        end
        RS_CMP: begin
          if (pair_ok) begin
            value   <= join_words(hi_a_q, lo_m_q);
            done    <= 1'b1;
            state_q <= RS_IDLE;
          end else begin
            state_q <= RS_HI_FIRST;
          end
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hi_a_q == hi_b_q) && (value == {hi_b_q, lo_m_q}));

  assert_read_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_HI_FIRST) |=> (state_q == RS_LO_MID));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_LO_MID && req) |=> (state_q == RS_HI_SECOND));
endmodule

// File: rtl/hwtime_core.sv
module hwtime_core #(
  parameter int HALF_W = 32,
  parameter int DIV    = 8,
  parameter int SYNC   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_sel,
  input  logic                ext_tick,
  input  logic                wr_lo_en,
  input  logic [HALF_W-1:0]   wr_lo_data,
  input  logic                wr_hi_en,
  input  logic [HALF_W-1:0]   wr_hi_data,
  input  logic                rd_lo_en,
  output logic [HALF_W-1:0]   rd_lo_data,
  input  logic                rd_hi_en,
  output logic [HALF_W-1:0]   rd_hi_data,
  input  logic                snap_req,
  output logic                snap_done,
  output logic [2*HALF_W-1:0] snap_value
);
  logic              any_write;
  logic              step;
  logic [HALF_W-1:0] lo_now, hi_now;

  assign any_write = wr_lo_en || wr_hi_en;

  hwtime_tick #(.DIV(DIV), .SYNC(SYNC)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_sel  (clk_sel),
    .ext_tick (ext_tick),
    .restart  (any_write),
    .tick_o   (step)
  );

  hwtime_count #(.HALF_W(HALF_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .wr_lo_en   (wr_lo_en),
    .wr_lo_data (wr_lo_data),
    .wr_hi_en   (wr_hi_en),
    .wr_hi_data (wr_hi_data),
    .rd_lo_en   (rd_lo_en),
    .rd_hi_en   (rd_hi_en),
    .rd_lo_data (rd_lo_data),
    .rd_hi_data (rd_hi_data),
    .lo_q       (lo_now),
    .hi_q       (hi_now)
  );

  hwtime_snap #(.HALF_W(HALF_W)) u_snap (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (snap_req),
    .lo_in (lo_now),
    .hi_in (hi_now),
    .done  (snap_done),
    .value (snap_value)
  );
endmodule

// File: tb/hwtime_core_bench.sv
module hwtime_core_bench;
  localparam int HW = 32;
  localparam int NV = 8;

  // preset, request offset (edges after the low write), expected value, expected latency
  localparam logic [63:0] V_PRE [NV] = '{
    64'h00000012_FFFFFFFF, 64'h00000012_FFFFFFFF, 64'h00000012_FFFFFFFF,
    64'h00000012_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 64'hA5A5A5A5_00000010,
    64'h00000000_FFFFFFF0, 64'h00000007_FFFFFFFF};
  localparam int V_OFF [NV] = '{7, 6, 5, 8, 7, 3, 20, 15};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h00000013_00000000, 64'h00000013_00000000, 64'h00000012_FFFFFFFF,
    64'h00000013_00000000, 64'h00000000_00000000, 64'hA5A5A5A5_00000010,
    64'h00000000_FFFFFFF2, 64'h00000008_00000001};
  localparam int V_LAT [NV] = '{8, 8, 4, 4, 8, 4, 4, 4};

  logic clk = 0, rst_n = 0, clk_sel = 0, ext_tick = 0;
  logic wr_lo_en = 0, wr_hi_en = 0, rd_lo_en = 0, rd_hi_en = 0, snap_req = 0;
  logic [HW-1:0] wr_lo_data = '0, wr_hi_data = '0, rd_lo_data, rd_hi_data;
  logic snap_done;
  logic [2*HW-1:0] snap_value;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  hwtime_core u_hwtime_core (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_tick(ext_tick),
    .wr_lo_en(wr_lo_en), .wr_lo_data(wr_lo_data),
    .wr_hi_en(wr_hi_en), .wr_hi_data(wr_hi_data),
    .rd_lo_en(rd_lo_en), .rd_lo_data(rd_lo_data),
    .rd_hi_en(rd_hi_en), .rd_hi_data(rd_hi_data),
    .snap_req(snap_req), .snap_done(snap_done), .snap_value(snap_value));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [63:0] v);
    @(negedge clk); wr_hi_en = 1; wr_hi_data = v[63:32];
    @(negedge clk); wr_hi_en = 0; wr_lo_en = 1; wr_lo_data = v[31:0];
    @(posedge clk);
    @(negedge clk); wr_lo_en = 0;
  endtask

  task automatic snapshot(input logic [63:0] pre, input int off, input logic [63:0] exp,
                          input int lat, input bit extra_req, input string tag);
    int k = 0;
    int extra_done = 0;
    load(pre);
    repeat (off - 1) @(posedge clk);
    @(negedge clk); snap_req = 1;
    @(posedge clk);
    @(negedge clk); snap_req = 0;
    while (!snap_done && k < 40) begin
      @(posedge clk); @(negedge clk); k++;
      if (extra_req) snap_req = (k == 1 || k == 2);
    end
    snap_req = 0;
    check({tag, " latency"}, 64'(k), 64'(lat));
    check({tag, " value"}, snap_value, exp);
    @(posedge clk); @(negedge clk);
    check("R9 done one cycle", 64'(snap_done), 64'd0);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      if (snap_done) extra_done++;
    end
    check("R9 value held", snap_value, exp);
    check("R10 no extra done", 64'(extra_done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset done", 64'(snap_done), 64'd0);
    check("R1 reset value", snap_value, 64'd0);
    rst_n = 1;
    @(negedge clk); rd_lo_en = 1; rd_hi_en = 1;
    @(posedge clk); @(negedge clk);
    check("R1 low after reset", 64'(rd_lo_data), 64'd0);
    check("R1 high after reset", 64'(rd_hi_data), 64'd0);
    rd_lo_en = 0; rd_hi_en = 0;

    // Table walk: R7 and R8, including a low-word rollover between the two high reads
    for (int v = 0; v < NV; v++)
      snapshot(V_PRE[v], V_OFF[v], V_EXP[v], V_LAT[v], 1'b0, (V_LAT[v] == 8) ? "R8" : "R7");

    // R10: extra requests during a running snapshot
    snapshot(64'h00000001_00000100, 3, 64'h00000001_00000100, 4, 1'b1, "R10");

    // R2: divided stepping, R5 read latency
    load(64'd0);
    repeat (7) @(posedge clk);
    @(negedge clk); rd_lo_en = 1;
    @(posedge clk); @(negedge clk);
    check("R2 before 8th edge", 64'(rd_lo_data), 64'd0);
    @(posedge clk); @(negedge clk);
    check("R2 after 8th edge", 64'(rd_lo_data), 64'd1);
    repeat (7) @(posedge clk); @(negedge clk);
    check("R2 before 16th edge", 64'(rd_lo_data), 64'd1);
    @(posedge clk); @(negedge clk);
    check("R5 read follows count", 64'(rd_lo_data), 64'd2);
    rd_lo_en = 0;
    repeat (5) @(posedge clk); @(negedge clk);
    check("R5 read data holds", 64'(rd_lo_data), 64'd2);

    // R4: half writes
    load(64'h00000007_00000055);
    rd_lo_en = 1; rd_hi_en = 1;
    @(posedge clk); @(negedge clk);
    check("R4 low loaded", 64'(rd_lo_data), 64'h55);
    check("R4 high loaded", 64'(rd_hi_data), 64'h7);
    rd_lo_en = 0; rd_hi_en = 0;
    wr_lo_en = 1; wr_lo_data = 32'hFFFFFFFF;
    @(posedge clk); @(negedge clk); wr_lo_en = 0; rd_hi_en = 1; rd_lo_en = 1;
    @(posedge clk); @(negedge clk);
    check("R4 low write keeps high", 64'(rd_hi_data), 64'h7);
    check("R4 low write value", 64'(rd_lo_data), 64'hFFFFFFFF);
    rd_lo_en = 0; rd_hi_en = 0;

    // R6: carry across halves (low written at W, step on W+8, read sampled on W+9)
    load(64'h00000003_FFFFFFFF);
    repeat (8) @(posedge clk);
    @(negedge clk); rd_lo_en = 1; rd_hi_en = 1;
    @(posedge clk); @(negedge clk);
    check("R6 carry low", 64'(rd_lo_data), 64'd0);
    check("R6 carry high", 64'(rd_hi_data), 64'd4);
    rd_lo_en = 0; rd_hi_en = 0;

    // R3: external tick mode
    clk_sel = 1;
    load(64'd0);
    repeat (30) @(posedge clk);
    @(negedge clk); rd_lo_en = 1;
    @(posedge clk); @(negedge clk);
    check("R3 divider ignored", 64'(rd_lo_data), 64'd0);
    for (int p = 0; p < 5; p++) begin
      ext_tick = 1; repeat (3) @(negedge clk);
      ext_tick = 0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R3 five external edges", 64'(rd_lo_data), 64'd5);
    rd_lo_en = 0;
    clk_sel = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule